// File: doc/BRIEF.md
# Delayed-Branch Next-PC Sequencer

This block produces the program-counter sequence for a 32-bit pipeline front end whose architecture has one branch delay slot. It keeps three registered addresses: the address of the instruction now executing (current PC), the address of the delay-slot candidate (next PC) and the address after that (next-next PC). When the valid strobe is high, a decoded control-transfer descriptor is applied and the three addresses advance by one instruction. The descriptor holds the transfer kind, a link flag, a likely flag, the 16-bit offset field, the 26-bit region target field, a 32-bit register operand and two precomputed condition bits.

Taken PC-relative branches and both jump forms redirect the next-next position, so the delay-slot instruction always runs first. A likely branch that is not taken squashes its delay slot: the annul output rises in the same cycle and the state moves past the slot. Link variants ask for a write of the return address (the branch address plus 8) to register 31, or to an alternate register index for the accumulator-condition branch class. Conditions are evaluated outside this block.

Top module: `pc_seq_dslot`

## Requirements
- R1: While `rst` is high at a clock edge, the current PC is loaded with `reset_vec`, the next PC with `reset_vec`+4 and the next-next PC with `reset_vec`+8.
- R2: While `step` is low, all three PCs keep their values and `annul` and `link_we` stay low.
- R3: Kind code 0 (and unused codes 5 to 7) is sequential: current takes next, next takes next-next, next-next adds 4; `cond`, `acc_cond`, `likely` and `link` have no effect.
- R4: The branch displacement is the offset field times 4, sign-extended from bit 17, so offset 0x8000 gives -131072 and 0x7FFF gives +131068.
- R5: Kind code 1 with `cond` high is a taken branch: current takes the old next PC, next becomes old next PC plus the displacement, next-next is that plus 4; `annul` stays low, with or without `likely`.
- R6: Kind code 1 with `cond` low and `likely` low advances exactly as the sequential case and keeps `annul` low.
- R7: A not-taken branch with `likely` high raises `annul` in the step cycle; the current PC becomes the old next-next PC, the next PC that plus 4 and the next-next PC that plus 8.
- R8: Kind code 2 is a region jump: its target keeps bits 31..28 of the current PC and puts the 26-bit field shifted left by two below them; next takes the target, next-next the target plus 4, current takes the old next PC; `cond` and `likely` have no effect.
- R9: Kind code 3 is a register jump: the target is `reg_op` unchanged, including its low two bits; it is unconditional and `likely` has no effect.
- R10: A step with `link` high and kind code 1 to 4 raises `link_we` in that cycle, whether or not a branch is taken, with `link_val` equal to the pre-step next-next PC and `link_idx` 31 for codes 1 to 3.
- R11: Kind code 4 is the accumulator-condition branch: it behaves as code 1 but takes its condition from `acc_cond`, ignores `cond`, and its link index is 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_vec | input | 32 | Address loaded into the current PC at reset |
| step | input | 1 | Valid-instruction strobe; state advances only when high |
| xfer_kind | input | 3 | 0 sequential, 1 branch, 2 region jump, 3 register jump, 4 accumulator branch |
| link | input | 1 | Link variant: request a return-address write |
| likely | input | 1 | Likely variant: annul the slot when not taken |
| br_off | input | 16 | Word offset field of a branch |
| jt_field | input | 26 | Word target field of a region jump |
| reg_op | input | 32 | Register operand holding a register-jump target |
| cond | input | 1 | Condition result for kind 1 |
| acc_cond | input | 1 | Condition result for kind 4 |
| pc | output | 32 | Current PC |
| npc | output | 32 | Next PC |
| nnpc | output | 32 | Next-next PC |
| annul | output | 1 | Delay slot of the stepped instruction is squashed |
| link_we | output | 1 | Return-address write request |
| link_idx | output | 6 | Destination register index of the link write |
| link_val | output | 32 | Return address to write |

## Verification
The bench sweeps every combination of kind code, `cond`, `acc_cond`, `likely` and `link` under four offset patterns: the largest positive offset, the most negative, minus one, and a pseudo-random word, so the sign-extension boundary at bit 17 and wraparound of the 32-bit address are separated from the plain add. The condition bits are swept independently so that a branch reading the wrong condition, or a jump reading any condition, shows up as a wrong next PC. Reset vectors are varied between runs so that region jumps see different upper PC bits, and register operands with non-zero low bits show that the register target is passed on untouched. Idle cycles with a full descriptor applied show that nothing moves without the strobe.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

   // Transfer kind codes presented at the xfer_kind port
   typedef enum logic [2:0] {
      XFER_SEQ     = 3'd0,
      XFER_BRANCH  = 3'd1,
      XFER_JREGION = 3'd2,
      XFER_JREG    = 3'd3,
      XFER_ACCBR   = 3'd4
   } xfer_e;

   // How the three-PC state advances on a step
   typedef enum logic [2:0] {
      ADV_SEQ     = 3'd0,
      ADV_SKIP    = 3'd1,
      ADV_BRANCH  = 3'd2,
      ADV_JREGION = 3'd3,
      ADV_JREG    = 3'd4
   } adv_e;

endpackage

// File: rtl/pcseq_target.sv
module pcseq_target #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16,
   parameter int JT_W   = 26
) (
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic [ADDR_W-1:0] nxt_pc,
   input  logic [OFF_W-1:0]  off_field,
   input  logic [JT_W-1:0]   jt_bits,
   output logic [ADDR_W-1:0] br_tgt,
   output logic [ADDR_W-1:0] rg_tgt
);
   localparam int DISP_W   = OFF_W + 2;
   localparam int EXT_W    = ADDR_W - DISP_W;
   localparam int REGION_W = ADDR_W - JT_W - 2;

   logic [ADDR_W-1:0] disp;

   generate
      if (EXT_W > 0) begin : g_ext
         assign disp = {{EXT_W{off_field[OFF_W-1]}}, off_field, 2'b00};
      end else begin : g_noext
         assign disp = {off_field, 2'b00};
      end
   endgenerate

   assign br_tgt = nxt_pc + disp;
   assign rg_tgt = {cur_pc[ADDR_W-1 -: REGION_W], jt_bits, 2'b00};

endmodule

// File: rtl/pcseq_decide.sv
module pcseq_decide
   import pcseq_pkg::*;
#(
   parameter int REG_IDX_W    = 6,
   parameter int LINK_IDX     = 31,
   parameter int ALT_LINK_IDX = 32,
   parameter bit ACC_BR_EN    = 1'b1
) (
   input  logic                 step,
   input  logic [2:0]           kind,
   input  logic                 link,
   input  logic                 likely,
   input  logic                 cond,
   input  logic                 acc_cond,
   output adv_e                 adv,
   output logic                 annul,
   output logic                 link_we,
   output logic [REG_IDX_W-1:0] link_idx
);
   logic is_acc;
   logic is_branch;
   logic is_ctl;
   logic taken;

   generate
      if (ACC_BR_EN) begin : g_acc
         assign is_acc = (kind == XFER_ACCBR);
      end else begin : g_noacc
         assign is_acc = 1'b0;
      end
   endgenerate

   assign is_branch = (kind == XFER_BRANCH) || is_acc;
   assign is_ctl    = is_branch || (kind == XFER_JREGION) || (kind == XFER_JREG);
   assign taken     = is_acc ? acc_cond : cond;

   always_comb begin
      adv = ADV_SEQ;
      if (is_branch) begin
         if (taken)       adv = ADV_BRANCH;
         else if (likely) adv = ADV_SKIP;
      end else if (kind == XFER_JREGION) begin
         adv = ADV_JREGION;
      end else if (kind == XFER_JREG) begin
         adv = ADV_JREG;
      end
   end

   assign annul    = step && (adv == ADV_SKIP);
   assign link_we  = step && link && is_ctl;
   assign link_idx = is_acc ? REG_IDX_W'(ALT_LINK_IDX) : REG_IDX_W'(LINK_IDX);

endmodule

// File: rtl/pcseq_state.sv
module pcseq_state
   import pcseq_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] reset_vec,
   input  logic              step,
   input  adv_e              adv,
   input  logic [ADDR_W-1:0] br_tgt,
   input  logic [ADDR_W-1:0] rg_tgt,
   input  logic [ADDR_W-1:0] reg_tgt,
   output logic [ADDR_W-1:0] pc_q,
   output logic [ADDR_W-1:0] npc_q,
   output logic [ADDR_W-1:0] nnpc_q
);
   localparam logic [ADDR_W-1:0] WORD  = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] DWORD = ADDR_W'(8);

   logic [ADDR_W-1:0] redirect;

   always_comb begin
      case (adv)
         ADV_BRANCH:  redirect = br_tgt;
         ADV_JREGION: redirect = rg_tgt;
         default:     redirect = reg_tgt;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q   <= reset_vec;
         npc_q  <= reset_vec + WORD;
         nnpc_q <= reset_vec + DWORD;
      end else if (step) begin
         case (adv)
            ADV_SEQ: begin
               pc_q   <= npc_q;
               npc_q  <= nnpc_q;
               nnpc_q <= nnpc_q + WORD;
            end
            ADV_SKIP: begin
               pc_q   <= nnpc_q;
               npc_q  <= nnpc_q + WORD;
               nnpc_q <= nnpc_q + DWORD;
            end
            default: begin
               pc_q   <= npc_q;
               npc_q  <= redirect;
               nnpc_q <= redirect + WORD;
            end
         endcase
      end
   end

endmodule

// File: rtl/pc_seq_dslot.sv
module pc_seq_dslot
   import pcseq_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int OFF_W        = 16,
   parameter int JT_W         = 26,
   parameter int REG_IDX_W    = 6,
   parameter int LINK_IDX     = 31,
   parameter int ALT_LINK_IDX = 32,
   parameter bit ACC_BR_EN    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [ADDR_W-1:0]    reset_vec,
   input  logic                 step,
   input  logic [2:0]           xfer_kind,
   input  logic                 link,
   input  logic                 likely,
   input  logic [OFF_W-1:0]     br_off,
   input  logic [JT_W-1:0]      jt_field,
   input  logic [ADDR_W-1:0]    reg_op,
   input  logic                 cond,
   input  logic                 acc_cond,
   output logic [ADDR_W-1:0]    pc,
   output logic [ADDR_W-1:0]    npc,
   output logic [ADDR_W-1:0]    nnpc,
   output logic                 annul,
   output logic                 link_we,
   output logic [REG_IDX_W-1:0] link_idx,
   output logic [ADDR_W-1:0]    link_val
);
   localparam int REGION_W = ADDR_W - JT_W - 2;

   generate
      if (REGION_W < 1)
         $error("pc_seq_dslot: JT_W leaves no region bits in ADDR_W");
      if (OFF_W + 2 > ADDR_W)
         $error("pc_seq_dslot: OFF_W too wide for ADDR_W");
      if (LINK_IDX >= (1 << REG_IDX_W) || ALT_LINK_IDX >= (1 << REG_IDX_W))
         $error("pc_seq_dslot: link index does not fit REG_IDX_W");
   endgenerate

   adv_e              adv;
   logic [ADDR_W-1:0] br_tgt;
   logic [ADDR_W-1:0] rg_tgt;

   pcseq_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .JT_W(JT_W)) u_target (
      .cur_pc   (pc),
      .nxt_pc   (npc),
      .off_field(br_off),
      .jt_bits  (jt_field),
      .br_tgt   (br_tgt),
      .rg_tgt   (rg_tgt)
   );

   pcseq_decide #(
      .REG_IDX_W   (REG_IDX_W),
      .LINK_IDX    (LINK_IDX),
      .ALT_LINK_IDX(ALT_LINK_IDX),
      .ACC_BR_EN   (ACC_BR_EN)
   ) u_decide (
      .step    (step),
      .kind    (xfer_kind),
      .link    (link),
      .likely  (likely),
      .cond    (cond),
      .acc_cond(acc_cond),
      .adv     (adv),
      .annul   (annul),
      .link_we (link_we),
      .link_idx(link_idx)
   );

   pcseq_state #(.ADDR_W(ADDR_W)) u_state (
      .clk      (clk),
      .rst      (rst),
      .reset_vec(reset_vec),
      .step     (step),
      .adv      (adv),
      .br_tgt   (br_tgt),
      .rg_tgt   (rg_tgt),
      .reg_tgt  (reg_op),
      .pc_q     (pc),
      .npc_q    (npc),
      .nnpc_q   (nnpc)
   );

   // return address is the pre-step next-next PC
   assign link_val = nnpc;

endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 16,
   parameter int JT_W   = 26
) (
   input logic              clk,
   input logic              rst,
   input logic              step,
   input logic [2:0]        xfer_kind,
   input logic              link,
   input logic              cond,
   input logic [OFF_W-1:0]  br_off,
   input logic [ADDR_W-1:0] reg_op,
   input logic [ADDR_W-1:0] pc,
   input logic [ADDR_W-1:0] npc,
   input logic [ADDR_W-1:0] nnpc,
   input logic              annul,
   input logic              link_we
);
   localparam int REGION_W = ADDR_W - JT_W - 2;

   logic signed [ADDR_W-1:0] disp_ref;
   always_comb disp_ref = ADDR_W'($signed(br_off)) * 4;

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(pc) && $stable(npc) && $stable(nnpc));

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !step |-> !annul && !link_we);

   // R5
   taken_branch_chk: assert property (@(posedge clk) disable iff (rst)
      (step && xfer_kind == 3'd1 && cond) |=>
         pc == $past(npc) && npc == $past(npc) + $past(disp_ref) && nnpc == npc + 4);

   // R7
   annul_skip_chk: assert property (@(posedge clk) disable iff (rst)
      annul |=> pc == $past(nnpc) && npc == $past(nnpc) + 4);

   // R8
   region_jump_chk: assert property (@(posedge clk) disable iff (rst)
      (step && xfer_kind == 3'd2) |=>
         npc[ADDR_W-1 -: REGION_W] == $past(pc[ADDR_W-1 -: REGION_W]) && nnpc == npc + 4);

   // R9
   reg_jump_chk: assert property (@(posedge clk) disable iff (rst)
      (step && xfer_kind == 3'd3) |=> npc == $past(reg_op) && pc == $past(npc));

   // R10
   link_gate_chk: assert property (@(posedge clk) disable iff (rst)
      link_we |-> link && step && xfer_kind != 3'd0);

endmodule

bind pc_seq_dslot pcseq_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .JT_W(JT_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .step     (step),
   .xfer_kind(xfer_kind),
   .link     (link),
   .cond     (cond),
   .br_off   (br_off),
   .reg_op   (reg_op),
   .pc       (pc),
   .npc      (npc),
   .nnpc     (nnpc),
   .annul    (annul),
   .link_we  (link_we)
);

// File: tb/pc_seq_dslot_tb.sv
`timescale 1ns/1ps
module pc_seq_dslot_tb;
   logic        clk = 1'b0;
   logic        rst;
   logic [31:0] reset_vec;
   logic        step;
   logic [2:0]  xfer_kind;
   logic        link, likely, cond, acc_cond;
   logic [15:0] br_off;
   logic [25:0] jt_field;
   logic [31:0] reg_op;
   logic [31:0] pc, npc, nnpc, link_val;
   logic        annul, link_we;
   logic [5:0]  link_idx;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;
   logic [31:0] m_pc, m_npc, m_nnpc;
   logic [31:0] seed = 32'h1234_5677;

   always #4 clk = ~clk;

   pc_seq_dslot u_dut (
      .clk(clk), .rst(rst), .reset_vec(reset_vec), .step(step),
      .xfer_kind(xfer_kind), .link(link), .likely(likely), .br_off(br_off),
      .jt_field(jt_field), .reg_op(reg_op), .cond(cond), .acc_cond(acc_cond),
      .pc(pc), .npc(npc), .nnpc(nnpc), .annul(annul), .link_we(link_we),
      .link_idx(link_idx), .link_val(link_val)
   );

   function automatic logic [31:0] rnd();
      seed ^= seed << 13;
      seed ^= seed >> 17;
      seed ^= seed << 5;
      return seed;
   endfunction

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // call at a negedge; leaves at the next negedge
   task automatic do_reset(logic [31:0] vec);
      rst = 1'b1; step = 1'b0; reset_vec = vec;
      @(posedge clk); @(negedge clk);
      rst = 1'b0;
      m_pc = vec; m_npc = vec + 32'd4; m_nnpc = vec + 32'd8;
      check("R1 pc", pc, m_pc);
      check("R1 npc", npc, m_npc);
      check("R1 nnpc", nnpc, m_nnpc);
   endtask

   task automatic do_step(logic [2:0] k, logic lk, logic ly, logic c, logic ac,
                          logic [15:0] off, logic [25:0] jt, logic [31:0] ro);
      logic signed [31:0] disp;
      logic [31:0] tgt;
      logic is_br, tk, ctl, exp_annul, redir;
      string tag;
      step = 1'b1; xfer_kind = k; link = lk; likely = ly; cond = c; acc_cond = ac;
      br_off = off; jt_field = jt; reg_op = ro;
      disp = $signed(off);
      disp = disp * 4;
      is_br = (k == 3'd1) || (k == 3'd4);
      tk    = (k == 3'd4) ? ac : c;
      ctl   = (k >= 3'd1) && (k <= 3'd4);
      exp_annul = is_br && !tk && ly;
      tag = (k == 3'd4) ? "R11" : (k == 3'd1) ? (exp_annul ? "R7" : (tk ? "R5" : "R6")) :
            (k == 3'd2) ? "R8" : (k == 3'd3) ? "R9" : "R3";
      #1;
      check({tag, " annul"}, 32'(annul), 32'(exp_annul));
      check("R10 link_we", 32'(link_we), 32'(lk && ctl));
      if (lk && ctl) begin
         check("R10 link_val", link_val, m_nnpc);
         check((k == 3'd4) ? "R11 link_idx" : "R10 link_idx", 32'(link_idx),
               (k == 3'd4) ? 32'd32 : 32'd31);
      end
      redir = 1'b0; tgt = 32'd0;
      if (is_br && tk)    begin redir = 1'b1; tgt = m_npc + disp; end
      else if (k == 3'd2) begin redir = 1'b1; tgt = (m_pc & 32'hF000_0000) | ({6'd0, jt} * 4); end
      else if (k == 3'd3) begin redir = 1'b1; tgt = ro; end
      @(posedge clk);
      if (redir) begin
         m_pc = m_npc; m_npc = tgt; m_nnpc = tgt + 32'd4;
      end else if (exp_annul) begin
         m_pc = m_nnpc; m_npc = m_nnpc + 32'd4; m_nnpc = m_nnpc + 32'd8;
      end else begin
         m_pc = m_npc; m_npc = m_nnpc; m_nnpc = m_nnpc + 32'd4;
      end
      @(negedge clk);
      step = 1'b0;
      check({tag, " R4 pc"}, pc, m_pc);
      check({tag, " R4 npc"}, npc, m_npc);
      check({tag, " nnpc"}, nnpc, m_nnpc);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] offs [4];
      step = 0; xfer_kind = 0; link = 0; likely = 0; cond = 0; acc_cond = 0;
      br_off = 0; jt_field = 0; reg_op = 0; rst = 1; reset_vec = 32'hBFC0_0000;
      @(negedge clk);
      do_reset(32'hBFC0_0000);

      // R2: idle with a full descriptor applied
      xfer_kind = 3'd1; link = 1; likely = 1; cond = 1; br_off = 16'h0040;
      #1;
      check("R2 link_we idle", 32'(link_we), 32'd0);
      check("R2 annul idle", 32'(annul), 32'd0);
      repeat (3) @(negedge clk);
      check("R2 pc hold", pc, m_pc);
      check("R2 npc hold", npc, m_npc);
      check("R2 nnpc hold", nnpc, m_nnpc);

      // R4 boundary offsets, then random
      offs[0] = 16'h7FFF; offs[1] = 16'h8000; offs[2] = 16'hFFFF;
      for (int p = 0; p < 4; p++) begin
         do_reset(rnd() & 32'hFFFF_FFFC);
         for (int v = 0; v < 256; v++) begin
            logic [15:0] o;
            o = (p < 3) ? offs[p] : rnd()[15:0];
            do_step(v[2:0], v[3], v[4], v[5], v[6], o, rnd()[25:0],
                    v[7] ? rnd() : (rnd() & 32'hFFFF_FFFC));
            if (v % 64 == 63) do_reset(rnd() & 32'hFFFF_FFFC);
         end
      end

      // R2: idle after activity
      repeat (2) @(negedge clk);
      check("R2 pc hold late", pc, m_pc);
      finish_run();
   end
endmodule